// File: doc/BRIEF.md
# Partitioned Pixel-by-Coefficient Rounding Multiplier

This block is a SIMD multiply stage for pixel processing. Each lane multiplies an unsigned 8-bit pixel value by a signed 16-bit coefficient. It keeps the middle sixteen bits of the product and rounds them up on the bit just below that window. Two 64-bit operands and a 3-bit mode code are accepted every clock. A 64-bit result, a valid flag and an illegal-mode flag come out two cycles later.

The mode code chooses where each lane takes its two factors and where its rounded result is written. The modes are:

- a four-lane mode with packed bytes;
- two broadcast-coefficient modes;
- two modes that take one byte out of each 16-bit lane;
- two wide modes that write only two results, each shifted up into a 32-bit slot.

All modes share the same four lane multipliers. The code value 7 is reserved.

Top module: `simd_pixel_mul`

## Requirements
- R1: Each lane computes P = F * C, where F is an unsigned 8-bit factor and C is a signed 16-bit coefficient. The lane value is P[23:8] plus P[7], taken modulo 2^16, with P in two's complement. A product of -128 therefore wraps to 0x0000.
- R2: Mode 0 (four-lane). For i = 0..3, F is opa_i[8i+7:8i] and C is opb_i[16i+15:16i]. The lane value goes to result_o[16i+15:16i].
- R3: Mode 1 uses C = opb_i[31:16] for all four lanes, and mode 2 uses C = opb_i[15:0] for all four lanes. In both, F and the placement are the same as in mode 0.
- R4: Mode 3 takes F = opa_i[16i+15:16i+8] and mode 4 takes F = opa_i[16i+7:16i]. In both, C and the placement are the same as in mode 0.
- R5: Modes 5 and 6 compute lanes 0 and 1 only. F is the high byte of each 16-bit lane of opa_i in mode 5 and the low byte in mode 6. C is opb_i[16i+15:16i]. Lane i goes to result_o[32i+22:32i+7].
- R6: In modes 5 and 6, every result bit outside the two lane windows is 0.
- R7: Mode 7 gives an all-zero result. illegal_o is 1 exactly when valid_o is 1 for a transaction that carried mode 7.
- R8: result_o reflects the opa_i, opb_i and mode_i values sampled two rising edges earlier. The data path advances on every edge, whether or not valid_i is set. valid_o equals valid_i from two edges earlier.
- R9: While rst_ni is low, and for the first two edges after it rises, result_o, valid_o and illegal_o are 0.
- R10: Operand bits that the active mode does not select have no effect on result_o. This covers opa_i[63:32] in modes 0 to 2, and opb_i[63:32] in modes 1, 2, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies the operands of this cycle |
| mode_i | input | 3 | Lane arrangement code, 0..6 legal, 7 reserved |
| opa_i | input | 64 | Pixel operand (unsigned bytes) |
| opb_i | input | 64 | Coefficient operand (signed 16-bit lanes) |
| valid_o | output | 1 | valid_i delayed by two cycles |
| result_o | output | 64 | Rounded and placed lane results |
| illegal_o | output | 1 | Reserved mode seen on a valid transaction |

## Verification
Every output is due exactly two rising edges after its operands are sampled. The bench drives new operands on each falling edge and pushes the expected values into a queue. On the next falling edge it pops the entry made two edges earlier and compares all three outputs against it. While the queue holds fewer than two entries, the expected outputs are the reset zeros. The bound checker ties valid_o and illegal_o to the inputs of two edges earlier. It uses its own counter of edges since reset, so it never looks back past the reset.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [2:0] {
    PM_QUAD     = 3'd0,
    PM_ALPHA_HI = 3'd1,
    PM_ALPHA_LO = 3'd2,
    PM_HI_BYTE  = 3'd3,
    PM_LO_BYTE  = 3'd4,
    PM_WIDE_HI  = 3'd5,
    PM_WIDE_LO  = 3'd6,
    PM_RSVD     = 3'd7
  } pm_mode_e;
endpackage

// File: rtl/pmul_operand_sel.sv
module pmul_operand_sel
  import pmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16
) (
  input  pm_mode_e                          mode_i,
  input  logic [LANES*COEF_W-1:0]           opa_i,
  input  logic [LANES*COEF_W-1:0]           opb_i,
  output logic [LANES-1:0][BYTE_W-1:0]      fac_o,
  output logic [LANES-1:0][COEF_W-1:0]      coef_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      case (mode_i)
        PM_HI_BYTE, PM_WIDE_HI: fac_o[i] = opa_i[i*COEF_W+BYTE_W +: BYTE_W];
        PM_LO_BYTE, PM_WIDE_LO: fac_o[i] = opa_i[i*COEF_W +: BYTE_W];
        default:                fac_o[i] = opa_i[i*BYTE_W +: BYTE_W];
      endcase
      case (mode_i)
        PM_ALPHA_HI: coef_o[i] = opb_i[COEF_W +: COEF_W];
        PM_ALPHA_LO: coef_o[i] = opb_i[0 +: COEF_W];
        default:     coef_o[i] = opb_i[i*COEF_W +: COEF_W];
      endcase
    end
  end
endmodule

// File: rtl/pmul_lane_mul.sv
module pmul_lane_mul #(
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16,
  localparam int PROD_W = BYTE_W + COEF_W
) (
  input  logic [BYTE_W-1:0] fac_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [PROD_W:0] fac_x, coef_x, full;
  always_comb begin
    fac_x  = {{(COEF_W+1){1'b0}}, fac_i};           // unsigned pixel
    coef_x = {{(BYTE_W+1){coef_i[COEF_W-1]}}, coef_i}; // signed coefficient
    full   = fac_x * coef_x;
    prod_o = full[PROD_W-1:0];
  end
endmodule

// File: rtl/pmul_place.sv
module pmul_place
  import pmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16,
  localparam int PROD_W = BYTE_W + COEF_W,
  localparam int DATA_W = LANES * COEF_W,
  localparam int WIDE_OFS = BYTE_W - 1
) (
  input  pm_mode_e                     mode_i,
  input  logic [LANES-1:0][PROD_W-1:0] prod_i,
  output logic [DATA_W-1:0]            res_o
);
  logic [LANES-1:0][COEF_W-1:0] rnd;

  for (genvar i = 0; i < LANES; i++) begin : g_rnd
    // middle window, rounded up on the first discarded bit
    assign rnd[i] = prod_i[i][PROD_W-1:BYTE_W]
                  + {{(COEF_W-1){1'b0}}, prod_i[i][BYTE_W-1]};
  end

  always_comb begin
    res_o = '0;
    case (mode_i)
      PM_RSVD: res_o = '0;
      PM_WIDE_HI, PM_WIDE_LO: begin
        for (int i = 0; i < LANES/2; i++)
          res_o[i*2*COEF_W+WIDE_OFS +: COEF_W] = rnd[i];
      end
      default: begin
        for (int i = 0; i < LANES; i++)
          res_o[i*COEF_W +: COEF_W] = rnd[i];
      end
    endcase
  end
endmodule

// File: rtl/simd_pixel_mul.sv
module simd_pixel_mul
  import pmul_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [2:0]              mode_i,
  input  logic [LANES*COEF_W-1:0] opa_i,
  input  logic [LANES*COEF_W-1:0] opb_i,
  output logic                    valid_o,
  output logic [LANES*COEF_W-1:0] result_o,
  output logic                    illegal_o
);
  localparam int PROD_W = BYTE_W + COEF_W;
  localparam int DATA_W = LANES * COEF_W;

  pm_mode_e                     mode_in;
  logic [LANES-1:0][BYTE_W-1:0] fac;
  logic [LANES-1:0][COEF_W-1:0] coef;
  logic [LANES-1:0][PROD_W-1:0] prod;
  logic [DATA_W-1:0]            placed;

  pm_mode_e                     s1_mode;
  logic [LANES-1:0][PROD_W-1:0] s1_prod;
  logic                         s1_valid;

  assign mode_in = pm_mode_e'(mode_i);

  pmul_operand_sel #(.LANES(LANES), .BYTE_W(BYTE_W), .COEF_W(COEF_W)) u_sel (
    .mode_i (mode_in),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .fac_o  (fac),
    .coef_o (coef)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    pmul_lane_mul #(.BYTE_W(BYTE_W), .COEF_W(COEF_W)) u_mul (
      .fac_i  (fac[i]),
      .coef_i (coef[i]),
      .prod_o (prod[i])
    );
  end

  // stage 1: raw products
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_mode  <= PM_QUAD;
      s1_prod  <= '0;
      s1_valid <= 1'b0;
    end else begin
      s1_mode  <= mode_in;
      s1_prod  <= prod;
      s1_valid <= valid_i;
    end
  end

  pmul_place #(.LANES(LANES), .BYTE_W(BYTE_W), .COEF_W(COEF_W)) u_place (
    .mode_i (s1_mode),
    .prod_i (s1_prod),
    .res_o  (placed)
  );

  // stage 2: rounded and placed result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      result_o  <= placed;
      valid_o   <= s1_valid;
      illegal_o <= s1_valid && (s1_mode == PM_RSVD);
    end
  end
endmodule

// File: rtl/pmul_checker.sv
module pmul_checker #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [2:0]              mode_i,
  input logic [2*COEF_W-1:0]     opa_lo_i,
  input logic                    valid_o,
  input logic [LANES*COEF_W-1:0] result_o,
  input logic                    illegal_o
);
  localparam int DATA_W = LANES * COEF_W;

  function automatic logic [DATA_W-1:0] wide_mask();
    logic [DATA_W-1:0] m = '0;
    for (int i = 0; i < LANES/2; i++) m[i*2*COEF_W+BYTE_W-1 +: COEF_W] = '1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] WMASK = wide_mask();

  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cyc <= 2'd0;
    else if (cyc != 2'd2)    cyc <= cyc + 2'd1;
  end

  logic bytes_eq;
  assign bytes_eq = (opa_lo_i[7:0] == opa_lo_i[15:8]) && (opa_lo_i[7:0] == opa_lo_i[23:16])
                 && (opa_lo_i[7:0] == opa_lo_i[31:24]);

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd2) |-> (valid_o == $past(valid_i, 2)));  // R8

  AST_FLUSH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 2'd2) |-> (!valid_o && !illegal_o));  // R9

  AST_ILLEGAL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd2) |-> (illegal_o == ($past(valid_i, 2) && ($past(mode_i, 2) == 3'd7))));  // R7

  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (valid_o && result_o == '0));  // R7

  AST_WIDE_UNUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc == 2'd2) && ($past(mode_i, 2) == 3'd5 || $past(mode_i, 2) == 3'd6))
      |-> ((result_o & ~WMASK) == '0));  // R6

  AST_ALPHA_BROADCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc == 2'd2) && ($past(mode_i, 2) == 3'd1 || $past(mode_i, 2) == 3'd2) && $past(bytes_eq, 2))
      |-> (result_o[15:0] == result_o[31:16] && result_o[15:0] == result_o[47:32]
           && result_o[15:0] == result_o[63:48]));  // R3
endmodule

bind simd_pixel_mul pmul_checker #(.LANES(LANES), .BYTE_W(BYTE_W), .COEF_W(COEF_W)) u_pmul_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .mode_i    (mode_i),
  .opa_lo_i  (opa_i[2*COEF_W-1:0]),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_simd_pixel_mul.sv
module tb_simd_pixel_mul;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        illegal_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [63:0] q_res[$];
  logic        q_val[$];
  logic        q_ill[$];
  string       q_tag[$];

  always #5 clk_i = ~clk_i;

  simd_pixel_mul dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .opa_i(opa_i), .opb_i(opb_i), .valid_o(valid_o), .result_o(result_o),
    .illegal_o(illegal_o)
  );

  // R1 lane arithmetic, computed with plain integers
  function automatic logic [15:0] lane_ref(int f, int c);
    int p = f * c;
    logic [31:0] pv = p;
    return 16'(pv[23:8] + {15'b0, pv[7]});
  endfunction

  function automatic logic [63:0] ref_mul(int m, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    int f, c, n;
    if (m == 7) return '0;
    n = (m >= 5) ? 2 : 4;
    for (int i = 0; i < n; i++) begin
      if (m == 3 || m == 5)      f = a[16*i+8 +: 8];
      else if (m == 4 || m == 6) f = a[16*i +: 8];
      else                       f = a[8*i +: 8];
      if (m == 1)      c = $signed(b[31:16]);
      else if (m == 2) c = $signed(b[15:0]);
      else             c = $signed(b[16*i +: 16]);
      if (m >= 5) r[32*i+7 +: 16] = lane_ref(f, c);
      else        r[16*i +: 16]   = lane_ref(f, c);
    end
    return r;
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      0: return "R2";
      1, 2: return "R3";
      3, 4: return "R4";
      5, 6: return "R5 R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare();
    logic [63:0] er = '0;
    logic ev = 1'b0, ei = 1'b0;
    string t = "R9";
    if (q_res.size() == 2) begin
      er = q_res.pop_front(); ev = q_val.pop_front();
      ei = q_ill.pop_front(); t = q_tag.pop_front();
    end
    n_vec++;
    if (result_o !== er || valid_o !== ev || illegal_o !== ei) begin
      n_bad++;
      $display("FAIL %s R8: res=%h exp=%h valid=%b exp=%b illegal=%b exp=%b",
               t, result_o, er, valid_o, ev, illegal_o, ei);
    end
  endtask

  task automatic apply(logic v, int m, logic [63:0] a, logic [63:0] b, string t);
    @(negedge clk_i);
    compare();
    valid_i = v; mode_i = 3'(m); opa_i = a; opb_i = b;
    q_res.push_back(ref_mul(m, a, b));
    q_val.push_back(v);
    q_ill.push_back(v && m == 7);
    q_tag.push_back(t);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk_i);
      compare();  // R9 during reset
    end
    rst_ni = 1'b1;
    // R1 extremes: 255*32767, 255*-32768, 1*-128 wraps to 0, 1*128 rounds to 1
    apply(1, 0, 64'h0000_0000_0101_FFFF, 64'h0080_FF80_8000_7FFF, "R1 R2");
    apply(1, 0, 64'h0000_0000_80FF_0102, 64'hFFFF_0001_7FFF_8000, "R1 R2");
    apply(1, 1, 64'h0000_0000_11FF_7F01, 64'h0000_0000_8001_1234, "R3");
    apply(1, 2, 64'h0000_0000_11FF_7F01, 64'h0000_0000_8001_1234, "R3");
    apply(1, 1, 64'h0000_0000_5A5A_5A5A, 64'h0000_0000_C350_0000, "R3");
    apply(1, 3, 64'hFF01_80AA_0100_7F33, 64'h7FFF_8000_FF80_0101, "R4");
    apply(1, 4, 64'hFF01_80AA_0100_7F33, 64'h7FFF_8000_FF80_0101, "R4");
    apply(1, 5, 64'hFFFF_FFFF_FF00_01FF, 64'hFFFF_FFFF_8000_7FFF, "R5 R6");
    apply(1, 6, 64'hFFFF_FFFF_FF00_01FF, 64'hFFFF_FFFF_8000_7FFF, "R5 R6");
    apply(1, 7, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    apply(0, 7, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    // R10 unselected bits carry garbage
    apply(1, 0, 64'hDEAD_BEEF_0203_0405, 64'h0100_0200_0300_0400, "R10");
    apply(1, 1, 64'hDEAD_BEEF_0203_0405, 64'hCAFE_F00D_0100_7777, "R10");
    apply(1, 2, 64'hDEAD_BEEF_0203_0405, 64'hCAFE_F00D_0100_7777, "R10");
    apply(1, 5, 64'h0000_0000_3300_4400, 64'hCAFE_F00D_0100_FF00, "R10");
    apply(0, 0, 64'h0000_0000_0101_0101, 64'h0100_0100_0100_0100, "R8");
    for (int k = 0; k < 800; k++) begin
      int m = int'($urandom_range(0, 7));
      apply(1'($urandom), m, {$urandom, $urandom}, {$urandom, $urandom}, mode_tag(m));
    end
    apply(0, 0, '0, '0, "R8");
    apply(0, 0, '0, '0, "R8");
    @(negedge clk_i);
    compare();
    @(negedge clk_i);
    compare();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule